// File: doc/BRIEF.md
# Instruction Cache Line Coherence Controller

This block tracks the coherence state of one line of a read-only instruction cache that sits below a shared second-level directory. It takes fetches from the core, replies from the directory and invalidate or downgrade probes. In return it produces shared-read requests, clean-victim notices, writeback data, stale notices, probe replies and unblock messages. A fetch that hits returns the line data to the core one cycle after the handshake. A fetch that misses either allocates the line or, when another address holds it, first evicts the resident copy into a victim buffer.

Every network message goes through a single output register with a valid/ready handshake. Each message carries a destination slice, which is taken from the address bits directly above the block offset. The three input channels are served by fixed priority and at most one input is consumed per cycle. The line has five states: invalid, shared, fill pending, victim pending and victim cancelled. The last three are transient: while the line is in one of them, fetches stall until the outstanding exchange with the directory finishes.

Top module: `icc_line_ctrl`

## Requirements
- R1: After reset the line is invalid and no message or core reply is pending. A fetch to an invalid line is accepted and emits a shared-read (net_type 0) with the line-aligned address (offset bits zero). No core reply is given until the fill arrives.
- R2: A fetch whose tag matches a shared line is accepted, emits no network message, and raises core_valid with the line data in the following cycle.
- R3: In fill pending, victim pending or victim cancelled, fetch_ready stays low, no message is emitted and the fetch is held.
- R4: A fetch to a different tag while the line is shared is not accepted. Instead the line data and dirty bit are copied into the victim buffer and a victim notice (net_type 1) is emitted for the old line with net_shared set and no data. The line becomes invalid and the controller enters victim pending.
- R5: A shared acknowledgement (resp_kind 0) in fill pending stores resp_data and resp_dirty, raises core_valid with that data, emits an unblock (net_type 5) for the line, and makes the line shared. The same reply in any other state is dropped.
- R6: In victim pending, a writeback acknowledgement (resp_kind 1) emits writeback data (net_type 2) with the buffered data, dirty bit and shared flag, then goes invalid. A writeback nack (resp_kind 2) goes invalid with no message. Either reply is dropped in the stable states.
- R7: An invalidating probe (prb_kind 0 without data, 1 with data) that hits the victim emits a no-data probe reply (net_type 4, net_hit 0) and enters victim cancelled. In that state a writeback acknowledgement emits a stale notice (net_type 3), and a nack emits nothing. Both end invalid.
- R8: A downgrade probe (prb_kind 2) that hits a shared line replies with net_hit 1, the line data and the line dirty bit, and the line stays shared. If it hits the victim in victim pending, the reply carries the buffered data and dirty bit and the victim's shared flag is set. Any other downgrade, and the reserved kind 3, gets a reply with net_hit 0 and no data.
- R9: An invalidating probe that hits the line during fill pending emits a no-data reply and keeps the line allocated, so the later fill still completes to shared.
- R10: On a shared line, an invalidating probe with data replies with net_hit 1 and the data, and a probe without data replies with net_hit 0. Both leave the line invalid. A probe to another address leaves the line unchanged.
- R11: net_dest equals net_addr[OFFS_BITS +: SLICE_BITS] for every message.
- R12: A valid response blocks probe and fetch readiness. A valid probe blocks fetch readiness.
- R13: While net_valid is high and net_ready low, the message holds stable and no input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Core fetch request valid |
| fetch_ready | output | 1 | Fetch accepted this cycle |
| fetch_addr | input | ADDR_W | Fetch byte address |
| core_valid | output | 1 | Fetch completion pulse |
| core_data | output | DATA_W | Line data returned to the core |
| resp_valid | input | 1 | Directory reply valid |
| resp_ready | output | 1 | Directory reply accepted |
| resp_kind | input | 2 | 0 shared ack, 1 writeback ack, 2 writeback nack |
| resp_data | input | DATA_W | Fill data |
| resp_dirty | input | 1 | Fill dirty bit |
| prb_valid | input | 1 | Probe valid |
| prb_ready | output | 1 | Probe accepted |
| prb_kind | input | 2 | 0 invalidate, 1 invalidate with data, 2 downgrade |
| prb_addr | input | ADDR_W | Probe byte address |
| net_valid | output | 1 | Outgoing message valid |
| net_ready | input | 1 | Network takes the message |
| net_type | output | 3 | Message type code |
| net_addr | output | ADDR_W | Line-aligned address |
| net_dest | output | DEST_W | Destination slice |
| net_data | output | DATA_W | Message data |
| net_dirty | output | 1 | Dirty flag |
| net_shared | output | 1 | Shared flag |
| net_hit | output | 1 | Probe reply carries data |

## Verification
Fetch handling is driven with hitting addresses that carry nonzero offset bits, with misses to an empty line and with misses to an occupied line. These cases separate a tag compare that ignores the offset from one that does not, and an allocation from an eviction. Probes are sent to the resident line, to the victim and to unrelated addresses, in every state. This separates a probe that matches the line tag from one that matches the victim tag, which is what makes the cancelled path observable. Directed orderings cover probes landing in the middle of a fill or a writeback, all three inputs arriving at once, and a stalled output. A seeded random walk then mixes all three channels and checks each response against a bench model of the line.

// File: rtl/icc_pkg.sv
package icc_pkg;
   typedef enum logic [2:0] {
      LS_INV  = 3'd0,
      LS_SHR  = 3'd1,
      LS_FILL = 3'd2,
      LS_VICT = 3'd3,
      LS_CANC = 3'd4
   } line_st_e;

   typedef enum logic [2:0] {
      NM_RDSHR   = 3'd0,
      NM_VICTIM  = 3'd1,
      NM_WBDATA  = 3'd2,
      NM_STALE   = 3'd3,
      NM_PRBRSP  = 3'd4,
      NM_UNBLOCK = 3'd5
   } net_msg_e;

   typedef enum logic [1:0] {
      PK_INV     = 2'd0,
      PK_INVDATA = 2'd1,
      PK_DOWN    = 2'd2,
      PK_RSVD    = 2'd3
   } prb_kind_e;

   typedef enum logic [1:0] {
      RK_SHRACK = 2'd0,
      RK_WBACK  = 2'd1,
      RK_WBNACK = 2'd2,
      RK_RSVD   = 2'd3
   } rsp_kind_e;

   localparam int MSG_TYPE_W = 3;
endpackage

// File: rtl/icc_slice_sel.sv
module icc_slice_sel #(
   parameter int ADDR_W     = 16,
   parameter int OFFS_BITS  = 6,
   parameter int SLICE_BITS = 2,
   parameter int DEST_W     = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DEST_W-1:0] dest
);
   generate
      if (SLICE_BITS == 0) begin : g_single
         wire unused_addr = ^addr;
         assign dest = '0;
      end else begin : g_sliced
         localparam int HI = OFFS_BITS + SLICE_BITS;
         if (HI < ADDR_W) begin : g_upper
            wire unused_hi = ^addr[ADDR_W-1:HI];
         end
         if (OFFS_BITS > 0) begin : g_lower
            wire unused_lo = ^addr[OFFS_BITS-1:0];
         end
         assign dest = addr[OFFS_BITS +: SLICE_BITS];
      end
   endgenerate
endmodule

// File: rtl/icc_outbuf.sv
module icc_outbuf #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_msg,
   output logic         can_take,
   output logic         out_valid,
   output logic [W-1:0] out_msg,
   input  logic         out_ready
);
   logic         v_q;
   logic [W-1:0] m_q;

   assign can_take  = !v_q || out_ready;
   assign out_valid = v_q;
   assign out_msg   = m_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= 1'b0;
         m_q <= '0;
      end else if (can_take) begin
         v_q <= in_valid;
         if (in_valid) m_q <= in_msg;
      end
   end
endmodule

// File: rtl/icc_line_fsm.sv
module icc_line_fsm
   import icc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int OFFS_BITS = 6,
   localparam int TAG_W    = ADDR_W - OFFS_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              can_emit,
   input  logic              fetch_valid,
   output logic              fetch_ready,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              core_valid,
   output logic [DATA_W-1:0] core_data,
   input  logic              resp_valid,
   output logic              resp_ready,
   input  logic [1:0]        resp_kind,
   input  logic [DATA_W-1:0] resp_data,
   input  logic              resp_dirty,
   input  logic              prb_valid,
   output logic              prb_ready,
   input  logic [1:0]        prb_kind,
   input  logic [ADDR_W-1:0] prb_addr,
   output logic              emit,
   output logic [2:0]        m_type,
   output logic [ADDR_W-1:0] m_addr,
   output logic [DATA_W-1:0] m_data,
   output logic              m_dirty,
   output logic              m_shared,
   output logic              m_hit
);
   line_st_e            st_q, st_d;
   logic [TAG_W-1:0]    ltag_q, ltag_d, vtag_q, vtag_d, m_tag;
   logic [DATA_W-1:0]   ldata_q, ldata_d, vdata_q, vdata_d, cdata_q, cdata_d;
   logic                ldirty_q, ldirty_d, vdirty_q, vdirty_d, vsh_q, vsh_d;
   logic                cval_d, cval_q;
   net_msg_e            mt;

   wire [TAG_W-1:0] f_tag = fetch_addr[ADDR_W-1:OFFS_BITS];
   wire [TAG_W-1:0] p_tag = prb_addr[ADDR_W-1:OFFS_BITS];
   wire unused_offs = ^{fetch_addr[OFFS_BITS-1:0], prb_addr[OFFS_BITS-1:0]};

   wire line_live = (st_q == LS_SHR) || (st_q == LS_FILL);
   wire vict_live = (st_q == LS_VICT) || (st_q == LS_CANC);
   wire line_hit  = line_live && (p_tag == ltag_q);
   wire vict_hit  = vict_live && (p_tag == vtag_q);

   assign resp_ready  = can_emit;
   assign prb_ready   = can_emit && !resp_valid;
   assign fetch_ready = can_emit && !resp_valid && !prb_valid &&
                        ((st_q == LS_INV) || (st_q == LS_SHR && f_tag == ltag_q));

   wire take_resp = resp_valid && resp_ready;
   wire take_prb  = prb_valid && prb_ready;
   wire fetch_go  = fetch_valid && can_emit && !resp_valid && !prb_valid;

   always_comb begin
      st_d     = st_q;
      ltag_d   = ltag_q;
      ldata_d  = ldata_q;
      ldirty_d = ldirty_q;
      vtag_d   = vtag_q;
      vdata_d  = vdata_q;
      vdirty_d = vdirty_q;
      vsh_d    = vsh_q;
      cval_d   = 1'b0;
      cdata_d  = cdata_q;
      emit     = 1'b0;
      mt       = NM_RDSHR;
      m_tag    = '0;
      m_data   = '0;
      m_dirty  = 1'b0;
      m_shared = 1'b0;
      m_hit    = 1'b0;
      if (take_resp) begin
         case (rsp_kind_e'(resp_kind))
            RK_SHRACK: if (st_q == LS_FILL) begin
               ldata_d  = resp_data;
               ldirty_d = resp_dirty;
               st_d     = LS_SHR;
               cval_d   = 1'b1;
               cdata_d  = resp_data;
               emit     = 1'b1;
               mt       = NM_UNBLOCK;
               m_tag    = ltag_q;
            end
            RK_WBACK: if (st_q == LS_VICT) begin
               emit     = 1'b1;
               mt       = NM_WBDATA;
               m_tag    = vtag_q;
               m_data   = vdata_q;
               m_dirty  = vdirty_q;
               m_shared = vsh_q;
               st_d     = LS_INV;
            end else if (st_q == LS_CANC) begin
               emit  = 1'b1;
               mt    = NM_STALE;
               m_tag = vtag_q;
               st_d  = LS_INV;
            end
            RK_WBNACK: if (vict_live) st_d = LS_INV;
            default: ;
         endcase
      end else if (take_prb) begin
         emit  = 1'b1;
         mt    = NM_PRBRSP;
         m_tag = p_tag;
         case (prb_kind_e'(prb_kind))
            PK_INV, PK_INVDATA: begin
               if (line_hit && st_q == LS_SHR) begin
                  if (prb_kind_e'(prb_kind) == PK_INVDATA) begin
                     m_hit   = 1'b1;
                     m_data  = ldata_q;
                     m_dirty = ldirty_q;
                  end
                  st_d = LS_INV;
               end else if (vict_hit && st_q == LS_VICT) begin
                  st_d = LS_CANC;
               end
            end
            PK_DOWN: begin
               if (line_hit && st_q == LS_SHR) begin
                  m_hit   = 1'b1;
                  m_data  = ldata_q;
                  m_dirty = ldirty_q;
               end else if (vict_hit && st_q == LS_VICT) begin
                  m_hit   = 1'b1;
                  m_data  = vdata_q;
                  m_dirty = vdirty_q;
                  vsh_d   = 1'b1;
               end
            end
            default: ;
         endcase
      end else if (fetch_go) begin
         if (st_q == LS_INV) begin
            emit   = 1'b1;
            mt     = NM_RDSHR;
            m_tag  = f_tag;
            ltag_d = f_tag;
            st_d   = LS_FILL;
         end else if (st_q == LS_SHR) begin
            if (f_tag == ltag_q) begin
               cval_d  = 1'b1;
               cdata_d = ldata_q;
            end else begin
               emit     = 1'b1;
               mt       = NM_VICTIM;
               m_tag    = ltag_q;
               m_shared = 1'b1;
               vtag_d   = ltag_q;
               vdata_d  = ldata_q;
               vdirty_d = ldirty_q;
               vsh_d    = 1'b0;
               st_d     = LS_VICT;
            end
         end
      end
   end

   assign m_type     = mt;
   assign m_addr     = {m_tag, {OFFS_BITS{1'b0}}};
   assign core_valid = cval_q;
   assign core_data  = cdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= LS_INV;
         ltag_q   <= '0;
         ldata_q  <= '0;
         ldirty_q <= 1'b0;
         vtag_q   <= '0;
         vdata_q  <= '0;
         vdirty_q <= 1'b0;
         vsh_q    <= 1'b0;
         cval_q   <= 1'b0;
         cdata_q  <= '0;
      end else begin
         st_q     <= st_d;
         ltag_q   <= ltag_d;
         ldata_q  <= ldata_d;
         ldirty_q <= ldirty_d;
         vtag_q   <= vtag_d;
         vdata_q  <= vdata_d;
         vdirty_q <= vdirty_d;
         vsh_q    <= vsh_d;
         cval_q   <= cval_d;
         cdata_q  <= cdata_d;
      end
   end
endmodule

// File: rtl/icc_line_ctrl.sv
module icc_line_ctrl
   import icc_pkg::*;
#(
   parameter int  ADDR_W     = 16,
   parameter int  DATA_W     = 32,
   parameter int  OFFS_BITS  = 6,
   parameter int  SLICE_BITS = 2,
   localparam int DEST_W     = (SLICE_BITS > 0) ? SLICE_BITS : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   output logic              fetch_ready,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              core_valid,
   output logic [DATA_W-1:0] core_data,
   input  logic              resp_valid,
   output logic              resp_ready,
   input  logic [1:0]        resp_kind,
   input  logic [DATA_W-1:0] resp_data,
   input  logic              resp_dirty,
   input  logic              prb_valid,
   output logic              prb_ready,
   input  logic [1:0]        prb_kind,
   input  logic [ADDR_W-1:0] prb_addr,
   output logic              net_valid,
   input  logic              net_ready,
   output logic [2:0]        net_type,
   output logic [ADDR_W-1:0] net_addr,
   output logic [DEST_W-1:0] net_dest,
   output logic [DATA_W-1:0] net_data,
   output logic              net_dirty,
   output logic              net_shared,
   output logic              net_hit
);
   localparam int MSG_W = MSG_TYPE_W + ADDR_W + DEST_W + DATA_W + 3;

   generate
      if (OFFS_BITS < 1 || OFFS_BITS + SLICE_BITS >= ADDR_W) begin : g_bad_geom
         $error("icc_line_ctrl: offset and slice bits must leave a tag");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("icc_line_ctrl: DATA_W must be positive");
      end
   endgenerate

   logic              can_emit, emit, m_dirty, m_shared, m_hit;
   logic [2:0]        m_type;
   logic [ADDR_W-1:0] m_addr;
   logic [DATA_W-1:0] m_data;
   logic [DEST_W-1:0] m_dest;
   logic [MSG_W-1:0]  msg_in, msg_out;

   icc_line_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_BITS(OFFS_BITS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .can_emit(can_emit),
      .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
      .core_valid(core_valid), .core_data(core_data),
      .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_kind(resp_kind),
      .resp_data(resp_data), .resp_dirty(resp_dirty),
      .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_kind(prb_kind), .prb_addr(prb_addr),
      .emit(emit), .m_type(m_type), .m_addr(m_addr), .m_data(m_data),
      .m_dirty(m_dirty), .m_shared(m_shared), .m_hit(m_hit)
   );

   icc_slice_sel #(.ADDR_W(ADDR_W), .OFFS_BITS(OFFS_BITS), .SLICE_BITS(SLICE_BITS),
                   .DEST_W(DEST_W)) u_slice (
      .addr(m_addr), .dest(m_dest)
   );

   assign msg_in = {m_type, m_addr, m_dest, m_data, m_dirty, m_shared, m_hit};

   icc_outbuf #(.W(MSG_W)) u_obuf (
      .clk(clk), .rst_n(rst_n), .in_valid(emit), .in_msg(msg_in), .can_take(can_emit),
      .out_valid(net_valid), .out_msg(msg_out), .out_ready(net_ready)
   );

   assign {net_type, net_addr, net_dest, net_data, net_dirty, net_shared, net_hit} = msg_out;
endmodule

// File: rtl/icc_line_ctrl_chk.sv
module icc_line_ctrl_chk #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int OFFS_BITS = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_ready,
   input logic              resp_valid,
   input logic              resp_ready,
   input logic              prb_valid,
   input logic              prb_ready,
   input logic              net_valid,
   input logic              net_ready,
   input logic [2:0]        net_type,
   input logic [ADDR_W-1:0] net_addr,
   input logic [DATA_W-1:0] net_data,
   input logic              net_shared,
   input logic              net_hit
);
   a_r12_resp_first: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (!prb_ready && !fetch_ready));

   a_r12_probe_before_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      prb_valid |-> !fetch_ready);

   a_r13_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (net_valid && !net_ready) |=> (net_valid && $stable(net_type) &&
                                     $stable(net_addr) && $stable(net_data)));

   a_r13_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (net_valid && !net_ready) |-> (!resp_ready && !prb_ready && !fetch_ready));

   a_r4_victim_shared: assert property (@(posedge clk) disable iff (!rst_n)
      (net_valid && net_type == 3'd1) |-> (net_shared && !net_hit));

   a_r1_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      net_valid |-> (net_addr[OFFS_BITS-1:0] == '0));
endmodule

bind icc_line_ctrl icc_line_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_BITS(OFFS_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fetch_ready(fetch_ready),
   .resp_valid(resp_valid), .resp_ready(resp_ready),
   .prb_valid(prb_valid), .prb_ready(prb_ready),
   .net_valid(net_valid), .net_ready(net_ready), .net_type(net_type),
   .net_addr(net_addr), .net_data(net_data), .net_shared(net_shared), .net_hit(net_hit)
);

// File: tb/icc_line_ctrl_test.sv
module icc_line_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16, DW = 32, OB = 6, SB = 2, TW = AW - OB;
   localparam int M_I = 0, M_S = 1, M_F = 2, M_V = 3, M_C = 4;

   logic clk = 0, rst_n = 0;
   logic fetch_valid = 0, resp_valid = 0, prb_valid = 0, net_ready = 1, resp_dirty = 0;
   logic [AW-1:0] fetch_addr = '0, prb_addr = '0;
   logic [1:0] resp_kind = '0, prb_kind = '0;
   logic [DW-1:0] resp_data = '0;
   logic fetch_ready, resp_ready, prb_ready, core_valid, net_valid;
   logic net_dirty, net_shared, net_hit;
   logic [DW-1:0] core_data, net_data;
   logic [2:0] net_type;
   logic [AW-1:0] net_addr;
   logic [SB-1:0] net_dest;

   icc_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .OFFS_BITS(OB), .SLICE_BITS(SB)) uut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // bench model of the line
   int ms = M_I;
   logic [TW-1:0] mtag, vtag;
   logic [DW-1:0] mdata, vdata;
   logic mdirty, vdirty, vsh;
   // expectations for one operation
   bit e_acc, e_v, e_dirty, e_sh, e_hit, e_cv;
   logic [2:0] e_type;
   logic [AW-1:0] e_addr;
   logic [DW-1:0] e_data, e_cd;

   function automatic logic [AW-1:0] line_of(input logic [TW-1:0] t);
      return {t, {OB{1'b0}}};
   endfunction

   function automatic logic [AW-1:0] pick_addr(input int i);
      case (i % 4)
         0: return 16'h0140;
         1: return 16'h0280;
         2: return 16'h03C0;
         default: return 16'h0500;
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clr_exp();
      e_acc = 1; e_v = 0; e_type = 0; e_addr = 0; e_data = 0; e_dirty = 0; e_sh = 0; e_hit = 0;
      e_cv = 0; e_cd = 0;
   endtask

   task automatic exp_msg(input logic [2:0] t, input logic [TW-1:0] tg);
      e_v = 1; e_type = t; e_addr = line_of(tg);
   endtask

   task automatic m_fetch(input logic [AW-1:0] a);
      logic [TW-1:0] ft = a[AW-1:OB];
      clr_exp();
      if (ms == M_I) begin
         exp_msg(3'd0, ft); mtag = ft; ms = M_F;
      end else if (ms == M_S && ft == mtag) begin
         e_cv = 1; e_cd = mdata;
      end else if (ms == M_S) begin
         e_acc = 0; exp_msg(3'd1, mtag); e_sh = 1;
         vtag = mtag; vdata = mdata; vdirty = mdirty; vsh = 0; ms = M_V;
      end else e_acc = 0;
   endtask

   task automatic m_probe(input logic [1:0] k, input logic [AW-1:0] a);
      logic [TW-1:0] pt = a[AW-1:OB];
      bit lh = (ms == M_S || ms == M_F) && pt == mtag;
      bit vh = (ms == M_V || ms == M_C) && pt == vtag;
      clr_exp();
      exp_msg(3'd4, pt);
      if (k <= 2'd1) begin
         if (lh && ms == M_S) begin
            if (k == 2'd1) begin e_hit = 1; e_data = mdata; e_dirty = mdirty; end
            ms = M_I;
         end else if (vh && ms == M_V) ms = M_C;
      end else if (k == 2'd2) begin
         if (lh && ms == M_S) begin e_hit = 1; e_data = mdata; e_dirty = mdirty; end
         else if (vh && ms == M_V) begin e_hit = 1; e_data = vdata; e_dirty = vdirty; vsh = 1; end
      end
   endtask

   task automatic m_resp(input logic [1:0] k, input logic [DW-1:0] d, input logic dy);
      clr_exp();
      if (k == 2'd0 && ms == M_F) begin
         mdata = d; mdirty = dy; ms = M_S; e_cv = 1; e_cd = d; exp_msg(3'd5, mtag);
      end else if (k == 2'd1 && ms == M_V) begin
         exp_msg(3'd2, vtag); e_data = vdata; e_dirty = vdirty; e_sh = vsh; ms = M_I;
      end else if (k == 2'd1 && ms == M_C) begin
         exp_msg(3'd3, vtag); ms = M_I;
      end else if (k == 2'd2 && (ms == M_V || ms == M_C)) ms = M_I;
   endtask

   task automatic check_out(input string req);
      chk(req, "net_valid", net_valid, e_v);
      if (e_v) begin
         chk(req, "net_type", net_type, e_type);
         chk(req, "net_addr", net_addr, e_addr);
         chk(req, "net_data", net_data, e_data);
         chk(req, "net_dirty", net_dirty, e_dirty);
         chk(req, "net_shared", net_shared, e_sh);
         chk(req, "net_hit", net_hit, e_hit);
         chk("R11", "net_dest", net_dest, e_addr[OB +: SB]);
      end
      chk(req, "core_valid", core_valid, e_cv);
      if (e_cv) chk(req, "core_data", core_data, e_cd);
   endtask

   task automatic run_fetch(input logic [AW-1:0] a, input string req);
      m_fetch(a);
      fetch_valid = 1; fetch_addr = a; #1;
      chk(req, "fetch_ready", fetch_ready, e_acc);
      @(posedge clk); @(negedge clk);
      check_out(req);
      fetch_valid = 0;
   endtask

   task automatic run_probe(input logic [1:0] k, input logic [AW-1:0] a, input string req);
      m_probe(k, a);
      prb_valid = 1; prb_kind = k; prb_addr = a; #1;
      chk(req, "prb_ready", prb_ready, 1'b1);
      @(posedge clk); @(negedge clk);
      check_out(req);
      prb_valid = 0;
   endtask

   task automatic run_resp(input logic [1:0] k, input logic [DW-1:0] d, input logic dy, input string req);
      m_resp(k, d, dy);
      resp_valid = 1; resp_kind = k; resp_data = d; resp_dirty = dy; #1;
      chk(req, "resp_ready", resp_ready, 1'b1);
      @(posedge clk); @(negedge clk);
      check_out(req);
      resp_valid = 0;
   endtask

   localparam logic [AW-1:0] A = 16'h0140, B = 16'h0280, C = 16'h03C0, D = 16'h0500;

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1", "reset net_valid", net_valid, 0);
      chk("R1", "reset core_valid", core_valid, 0);
      chk("R1", "reset fetch_ready", fetch_ready, 1);
      @(negedge clk);

      run_fetch(A + 3, "R1");
      run_fetch(A, "R3");
      run_probe(2'd2, A, "R8");
      run_resp(2'd0, 32'hCAFE0001, 1'b1, "R5");
      run_fetch(A + 8, "R2");
      run_probe(2'd2, A, "R8");
      run_fetch(A, "R8");
      run_probe(2'd0, B, "R10");
      run_fetch(B, "R4");
      run_fetch(B, "R3");
      run_probe(2'd2, A, "R8");
      run_resp(2'd1, 32'h0, 1'b0, "R6");
      run_fetch(B, "R1");
      run_probe(2'd0, B, "R9");
      run_resp(2'd0, 32'h12345678, 1'b0, "R9");
      run_fetch(B + 1, "R9");
      run_fetch(C, "R4");
      run_resp(2'd2, 32'h0, 1'b0, "R6");
      run_fetch(C, "R1");
      run_resp(2'd0, 32'h0BADF00D, 1'b1, "R5");
      run_fetch(D, "R4");
      run_probe(2'd1, C, "R7");
      run_probe(2'd2, C, "R8");
      run_fetch(D, "R3");
      run_resp(2'd1, 32'h0, 1'b0, "R7");
      run_fetch(D, "R1");
      run_resp(2'd0, 32'h5555AAAA, 1'b0, "R5");
      run_fetch(A, "R4");
      run_probe(2'd0, D, "R7");
      run_resp(2'd2, 32'h0, 1'b0, "R7");
      run_fetch(A, "R1");
      run_resp(2'd0, 32'h76543210, 1'b1, "R5");
      run_probe(2'd1, A, "R10");
      run_fetch(A, "R10");
      run_resp(2'd0, 32'hA5A5A5A5, 1'b0, "R5");
      run_resp(2'd1, 32'h0, 1'b0, "R6");
      run_probe(2'd3, A, "R8");
      run_probe(2'd0, A, "R10");

      // R12: all three channels at once while a fill is pending
      run_fetch(A, "R12");
      resp_valid = 1; resp_kind = 2'd0; resp_data = 32'hFEEDBEEF; resp_dirty = 1'b0;
      prb_valid = 1; prb_kind = 2'd0; prb_addr = C;
      fetch_valid = 1; fetch_addr = A;
      #1;
      chk("R12", "resp_ready", resp_ready, 1);
      chk("R12", "prb_ready blocked", prb_ready, 0);
      chk("R12", "fetch_ready blocked", fetch_ready, 0);
      @(posedge clk); @(negedge clk);
      m_resp(2'd0, 32'hFEEDBEEF, 1'b0);
      check_out("R12");
      resp_valid = 0; #1;
      chk("R12", "prb_ready", prb_ready, 1);
      chk("R12", "fetch_ready behind probe", fetch_ready, 0);
      @(posedge clk); @(negedge clk);
      m_probe(2'd0, C);
      check_out("R12");
      prb_valid = 0;
      run_fetch(A, "R12");

      // R13: stalled output
      net_ready = 0;
      run_probe(2'd0, B, "R13");
      prb_valid = 1; prb_kind = 2'd2; prb_addr = D; #1;
      chk("R13", "prb_ready stalled", prb_ready, 0);
      chk("R13", "fetch_ready stalled", fetch_ready, 0);
      @(posedge clk); @(negedge clk);
      chk("R13", "net_valid held", net_valid, 1);
      chk("R13", "net_addr held", net_addr, line_of(B[AW-1:OB]));
      net_ready = 1; #1;
      chk("R13", "prb_ready drain", prb_ready, 1);
      @(posedge clk); @(negedge clk);
      m_probe(2'd2, D);
      check_out("R13");
      prb_valid = 0;
      @(posedge clk); @(negedge clk);

      // seeded random walk
      for (int i = 0; i < 600; i++) begin
         int r = $urandom % 10;
         logic [AW-1:0] a = pick_addr($urandom % 4) | AW'($urandom % 64);
         if (ms == M_F || ms == M_V || ms == M_C) begin
            if (r < 3) run_probe(2'($urandom % 4), ($urandom % 2) ? line_of(ms == M_F ? mtag : vtag) : a, "R8");
            else if (r == 3) run_fetch(a, "R3");
            else if (ms == M_F) run_resp((r == 9) ? 2'd1 : 2'd0, $urandom, 1'($urandom), "R5");
            else run_resp((r < 7) ? 2'd1 : 2'd2, 32'h0, 1'b0, "R6");
         end else begin
            if (r < 6) run_fetch(a, "R2");
            else if (r < 9) run_probe(2'($urandom % 4), a, "R10");
            else run_resp(2'($urandom % 3), $urandom, 1'b1, "R6");
         end
      end

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule